// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a small register file on a plain synchronous bus (address, write data, write strobe, combinational read data). A prescaler turns the core clock into a slow tick, nominally 0.6 s. While the halt control bit is clear, the counter drops by one on every tick. Software keeps the system alive by writing the reload register, which copies the programmed initial value into the counter.

If software misses a deadline, the counter runs out. On the first expiry the block sets a first-stage timeout flag, can pulse an interrupt request, and restarts the countdown from the initial value. If the counter runs out again while that flag is still set, the block records a second-stage flag and pulses a system reset request. It does not pulse the reset request if the no-reboot inhibit bit is set. After a second expiry the counter parks at zero until software reloads it.

Clearing the first-stage flag therefore means two full countdowns are again needed before a reset. A boot-status flag, set by reset, lets firmware tell that a boot has not yet been acknowledged.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the halt bit (bit 11 at offset 0x08) reads 1, the no-reboot bit and interrupt enable read 0, the initial value at offset 0x12 reads 0x032, the count at offset 0x00 reads 0x032, and both outputs are 0.
- R2: With halt clear, the count drops by exactly one every TICK_DIV clocks; with TICK_DIV = 1 it drops by one on every clock.
- R3: While the halt bit is 1, the count holds its value.
- R4: Any write to offset 0x00 loads the count from the initial value on the next edge. A read of offset 0x00 returns the live count in bits 9:0, with bits 15:10 reading 0.
- R5: A write to offset 0x12 stores bits 9:0 only. A read returns the stored 10-bit value, with bits 15:10 reading 0.
- R6: A write of 0, 1, 2 or 3 to offset 0x12 is ignored, and the previous initial value is kept.
- R7: A tick that finds the count at zero, while the first-stage flag (bit 3 at offset 0x04) is clear, sets that flag and reloads the count from the initial value.
- R8: On a first-stage expiry, irq_o pulses high for one cycle if and only if interrupt enable (bit 13 at offset 0x0C) is 1.
- R9: A tick that finds the count at zero while the first-stage flag is set does three things. It sets the second-stage flag (bit 1 at offset 0x06) and issues a one-cycle sys_reset_req_o pulse. The count then stays at zero until a reload write or reset.
- R10: While the no-reboot bit (bit 0 at offset 0x08) is 1, a second-stage expiry records bit 1 at offset 0x06 but issues no sys_reset_req_o pulse.
- R11: Status bits are write-1-to-clear: bit 3 at offset 0x04, and bits 1 and 2 at offset 0x06. Writing 0 to a status bit leaves it unchanged, and a hardware set wins over a clear in the same cycle.
- R12: The boot-status flag (bit 2 at offset 0x06) reads 1 after reset and stays 1 until it is cleared by writing 1 to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse on first-stage expiry |
| sys_reset_req_o | output | 1 | One-cycle system reset request on second-stage expiry |

## Verification
The main instance is built with TICK_DIV = 4 and a 5-tick initial value. A full countdown then lasts about two dozen clocks, so first expiry, second expiry, parking at zero and the no-reboot case all occur within a few hundred cycles. These cycles also cover the prescaler phase, which runs freely against register writes. A second instance is built with TICK_DIV = 1 to reach the tick-per-clock mode. There, consecutive reads of the live count must differ by exactly one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int DATA_W = 16;

    // register byte offsets
    localparam int OFS_RELOAD = 'h00;
    localparam int OFS_STAT1  = 'h04;
    localparam int OFS_STAT2  = 'h06;
    localparam int OFS_CTRL   = 'h08;
    localparam int OFS_IRQEN  = 'h0C;
    localparam int OFS_INIT   = 'h12;

    // bit positions
    localparam int BIT_STAGE1   = 3;
    localparam int BIT_STAGE2   = 1;
    localparam int BIT_BOOT     = 2;
    localparam int BIT_HALT     = 11;
    localparam int BIT_NOREBOOT = 0;
    localparam int BIT_IRQEN    = 13;

    typedef struct packed {
        logic halt;
        logic noreboot;
        logic irq_en;
        logic stage1;
        logic stage2;
        logic boot;
    } wdog_flags_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int TICK_DIV = 60_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    generate
        if (TICK_DIV <= 1) begin : g_every_clock
            assign tick_o = 1'b1;
        end else begin : g_divider
            localparam int PRE_W = $clog2(TICK_DIV);
            localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

            logic [PRE_W-1:0] pre_d, pre_q;
            logic             wrap;

            always_comb begin
                wrap  = (pre_q == LAST);
                pre_d = wrap ? '0 : pre_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (rst) pre_q <= '0;
                else     pre_q <= pre_d;
            end

            assign tick_o = wrap;
        end
    endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 'h032
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             halt_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] init_i,
    input  logic             stage1_i,
    input  logic             irq_en_i,
    input  logic             noreboot_i,
    output logic [CNT_W-1:0] count_o,
    output logic             first_o,
    output logic             second_o,
    output logic             irq_o,
    output logic             sysrst_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             park;
        logic             irq;
        logic             sysrst;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      step, at_zero, expire;

    always_comb begin
        st_d     = st_q;
        step     = tick_i && !halt_i && !st_q.park;
        at_zero  = (st_q.cnt == '0);
        expire   = step && at_zero && !reload_i;
        first_o  = expire && !stage1_i;
        second_o = expire && stage1_i;

        st_d.irq    = first_o && irq_en_i;
        st_d.sysrst = second_o && !noreboot_i;

        if (reload_i) begin
            st_d.cnt  = init_i;
            st_d.park = 1'b0;
        end else if (step) begin
            if (!at_zero)      st_d.cnt  = st_q.cnt - 1'b1;
            else if (stage1_i) st_d.park = 1'b1;
            else               st_d.cnt  = init_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt    <= CNT_W'(INIT_RST);
            st_q.park   <= 1'b0;
            st_q.irq    <= 1'b0;
            st_q.sysrst <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign irq_o    = st_q.irq;
    assign sysrst_o = st_q.sysrst;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 'h032,
    parameter int INIT_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              we_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              first_i,
    input  logic              second_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              reload_o,
    output logic [CNT_W-1:0]  init_o,
    output wdog_flags_t       flags_o
);
    localparam logic [DATA_W-1:0] INIT_MASK = DATA_W'((1 << CNT_W) - 1);

    typedef struct packed {
        wdog_flags_t      fl;
        logic [CNT_W-1:0] init;
    } rg_state_t;

    rg_state_t         rg_d, rg_q;
    logic [DATA_W-1:0] masked;
    logic [CNT_W-1:0]  init_field;
    logic              hit_stat1, hit_stat2, hit_ctrl, hit_irqen, hit_init;

    always_comb begin
        rg_d       = rg_q;
        hit_stat1  = we_i && (addr_i == ADDR_W'(OFS_STAT1));
        hit_stat2  = we_i && (addr_i == ADDR_W'(OFS_STAT2));
        hit_ctrl   = we_i && (addr_i == ADDR_W'(OFS_CTRL));
        hit_irqen  = we_i && (addr_i == ADDR_W'(OFS_IRQEN));
        hit_init   = we_i && (addr_i == ADDR_W'(OFS_INIT));
        reload_o   = we_i && (addr_i == ADDR_W'(OFS_RELOAD));
        masked     = wdata_i & INIT_MASK;
        init_field = masked[CNT_W-1:0];

        if (hit_ctrl) begin
            rg_d.fl.halt     = wdata_i[BIT_HALT];
            rg_d.fl.noreboot = wdata_i[BIT_NOREBOOT];
        end
        if (hit_irqen) rg_d.fl.irq_en = wdata_i[BIT_IRQEN];
        if (hit_init && (init_field >= CNT_W'(INIT_MIN))) rg_d.init = init_field;

        if (hit_stat1 && wdata_i[BIT_STAGE1]) rg_d.fl.stage1 = 1'b0;
        if (hit_stat2 && wdata_i[BIT_STAGE2]) rg_d.fl.stage2 = 1'b0;
        if (hit_stat2 && wdata_i[BIT_BOOT])   rg_d.fl.boot   = 1'b0;
        if (first_i)  rg_d.fl.stage1 = 1'b1;
        if (second_i) rg_d.fl.stage2 = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rg_q.fl.halt     <= 1'b1;
            rg_q.fl.noreboot <= 1'b0;
            rg_q.fl.irq_en   <= 1'b0;
            rg_q.fl.stage1   <= 1'b0;
            rg_q.fl.stage2   <= 1'b0;
            rg_q.fl.boot     <= 1'b1;
            rg_q.init        <= CNT_W'(INIT_RST);
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(OFS_RELOAD): rdata_o = DATA_W'(count_i);
            ADDR_W'(OFS_STAT1):  rdata_o[BIT_STAGE1] = rg_q.fl.stage1;
            ADDR_W'(OFS_STAT2): begin
                rdata_o[BIT_STAGE2] = rg_q.fl.stage2;
                rdata_o[BIT_BOOT]   = rg_q.fl.boot;
            end
            ADDR_W'(OFS_CTRL): begin
                rdata_o[BIT_HALT]     = rg_q.fl.halt;
                rdata_o[BIT_NOREBOOT] = rg_q.fl.noreboot;
            end
            ADDR_W'(OFS_IRQEN):  rdata_o[BIT_IRQEN] = rg_q.fl.irq_en;
            ADDR_W'(OFS_INIT):   rdata_o = DATA_W'(rg_q.init);
            default:             rdata_o = '0;
        endcase
    end

    assign init_o  = rg_q.init;
    assign flags_o = rg_q.fl;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CNT_W    = 10,
    parameter int TICK_DIV = 60_000_000,
    parameter int INIT_RST = 'h032,
    parameter int INIT_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    output logic              irq_o,
    output logic              sys_reset_req_o
);
    logic             tick_w, reload_w, first_w, second_w;
    logic [CNT_W-1:0] count_w, init_w;
    wdog_flags_t      flags_w;

    wdog_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    wdog_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .we_i     (bus_we),
        .count_i  (count_w),
        .first_i  (first_w),
        .second_i (second_w),
        .rdata_o  (bus_rdata),
        .reload_o (reload_w),
        .init_o   (init_w),
        .flags_o  (flags_w)
    );

    wdog_countdown #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_cd (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_w),
        .halt_i     (flags_w.halt),
        .reload_i   (reload_w),
        .init_i     (init_w),
        .stage1_i   (flags_w.stage1),
        .irq_en_i   (flags_w.irq_en),
        .noreboot_i (flags_w.noreboot),
        .count_o    (count_w),
        .first_o    (first_w),
        .second_o   (second_w),
        .irq_o      (irq_o),
        .sysrst_o   (sys_reset_req_o)
    );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init,
    input logic             reload,
    input logic             halt,
    input logic             noreboot,
    input logic             irq_en,
    input logic             stage1,
    input logic             stage2,
    input logic             irq,
    input logic             sysrst
);
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst) (halt && !reload) |=> $stable(count)); // R3
    AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (rst) reload |=> (count == $past(init))); // R4
    AST_INIT_FLOOR: assert property (@(posedge clk) disable iff (rst) init >= CNT_W'(INIT_MIN)); // R6
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst) irq |-> ($past(irq_en) && stage1)); // R8
    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) sysrst |=> !sysrst); // R9
    AST_RST_RECORDED: assert property (@(posedge clk) disable iff (rst) sysrst |-> stage2); // R9
    AST_NOREBOOT_GATE: assert property (@(posedge clk) disable iff (rst) sysrst |-> !$past(noreboot)); // R10
endmodule

bind wdog_two_stage wdog_checker #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .count    (count_w),
    .init     (init_w),
    .reload   (reload_w),
    .halt     (flags_w.halt),
    .noreboot (flags_w.noreboot),
    .irq_en   (flags_w.irq_en),
    .stage1   (flags_w.stage1),
    .stage2   (flags_w.stage2),
    .irq      (irq_o),
    .sysrst   (sys_reset_req_o)
);

// File: tb/wdog_two_stage_tb_top.sv
module wdog_two_stage_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  b_addr = '0;
    logic [15:0] b_wdata = '0;
    logic        b_we = 1'b0;
    logic [15:0] b_rdata;
    logic        irq, sysrst;

    logic [4:0]  f_addr = '0;
    logic [15:0] f_wdata = '0;
    logic        f_we = 1'b0;
    logic [15:0] f_rdata;
    logic        f_irq, f_sysrst;

    int vectors = 0;
    int fails = 0;
    int irq_cnt = 0;
    int rst_cnt = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    wdog_two_stage #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_we(b_we),
        .bus_rdata(b_rdata), .irq_o(irq), .sys_reset_req_o(sysrst)
    );

    wdog_two_stage #(.TICK_DIV(1)) dut_fast_i (
        .clk(clk), .rst(rst), .bus_addr(f_addr), .bus_wdata(f_wdata), .bus_we(f_we),
        .bus_rdata(f_rdata), .irq_o(f_irq), .sys_reset_req_o(f_sysrst)
    );

    // behavioural reference model
    int m_pre, m_cnt, m_init;
    bit m_halt, m_nr, m_ien, m_f1, m_f2, m_boot, m_park, m_irq, m_rst;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_cnt = 'h32; m_init = 'h32;
            m_halt = 1; m_nr = 0; m_ien = 0; m_f1 = 0; m_f2 = 0; m_boot = 1;
            m_park = 0; m_irq = 0; m_rst = 0;
        end else begin
            bit tick, run, reload, ex, first, second;
            int nx_init;
            tick   = (m_pre == DIV - 1);
            m_pre  = tick ? 0 : m_pre + 1;
            reload = b_we && (b_addr == 5'h00);
            run    = tick && !m_halt && !m_park;
            ex     = run && (m_cnt == 0) && !reload;
            first  = ex && !m_f1;
            second = ex && m_f1;
            m_irq  = first && m_ien;
            m_rst  = second && !m_nr;
            nx_init = m_init;
            if (reload) begin
                m_cnt = m_init; m_park = 0;
            end else if (run) begin
                if (m_cnt != 0) m_cnt = m_cnt - 1;
                else if (m_f1)  m_park = 1;
                else            m_cnt = m_init;
            end
            if (b_we) begin
                case (b_addr)
                    5'h04: if (b_wdata[3]) m_f1 = 0;
                    5'h06: begin
                        if (b_wdata[1]) m_f2 = 0;
                        if (b_wdata[2]) m_boot = 0;
                    end
                    5'h08: begin m_halt = b_wdata[11]; m_nr = b_wdata[0]; end
                    5'h0C: m_ien = b_wdata[13];
                    5'h12: if (int'(b_wdata[9:0]) >= 4) nx_init = int'(b_wdata[9:0]);
                    default: ;
                endcase
            end
            m_init = nx_init;
            if (first)  m_f1 = 1;
            if (second) m_f2 = 1;
        end
    end

    function automatic logic [15:0] model_read(logic [4:0] a);
        logic [15:0] r;
        r = '0;
        case (a)
            5'h00: r = 16'(m_cnt);
            5'h04: r[3] = m_f1;
            5'h06: begin r[1] = m_f2; r[2] = m_boot; end
            5'h08: begin r[11] = m_halt; r[0] = m_nr; end
            5'h0C: r[13] = m_ien;
            5'h12: r = 16'(m_init);
            default: r = '0;
        endcase
        return r;
    endfunction

    // compare on every clock, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (!rst) begin
            vectors++;
            if (irq) irq_cnt++;
            if (sysrst) rst_cnt++;
            if (b_rdata !== model_read(b_addr) || irq !== m_irq || sysrst !== m_rst) begin
                fails++;
                $display("FAIL %s cycle compare addr=%h: rdata=%h irq=%b rst=%b, expected rdata=%h irq=%b rst=%b",
                         cur_req, b_addr, b_rdata, irq, sysrst, model_read(b_addr), m_irq, m_rst);
            end
        end
    end

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        b_addr = a; b_wdata = d; b_we = 1'b1;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        b_addr = a; b_we = 1'b0;
        #1;
        v = b_rdata;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, v1, v2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R12 reset state
        cur_req = "R1";
        rd(5'h00, v); check("R1 count", v, 16'h0032);
        rd(5'h12, v); check("R1 init", v, 16'h0032);
        rd(5'h08, v); check("R1 ctrl", v, 16'h0800);
        rd(5'h0C, v); check("R1 irq enable", v, 16'h0000);
        rd(5'h04, v); check("R1 stat1", v, 16'h0000);
        rd(5'h06, v); check("R12 boot flag set", v, 16'h0004);
        check("R1 outputs idle", {14'b0, irq, sysrst}, 16'h0000);

        // R2 tick-per-clock instance
        cur_req = "R2";
        @(negedge clk); f_addr = 5'h08; f_wdata = 16'h0000; f_we = 1'b1;
        @(negedge clk); f_we = 1'b0; f_addr = 5'h00;
        cycles(3);
        #1; v1 = f_rdata;
        @(negedge clk); #1; v2 = f_rdata;
        check("R2 one per clock", v1 - v2, 16'h0001);

        // R5 / R6 initial value register
        cur_req = "R6";
        wr(5'h12, 16'h0003);
        rd(5'h12, v); check("R6 tiny value ignored", v, 16'h0032);
        cur_req = "R5";
        wr(5'h12, 16'hFC05);
        rd(5'h12, v); check("R5 field only", v, 16'h0005);

        // R4 reload
        cur_req = "R4";
        wr(5'h00, 16'h0000);
        rd(5'h00, v); check("R4 reload value", v, 16'h0005);

        // R2 / R3 countdown and halt
        cur_req = "R3";
        wr(5'h08, 16'h0000);
        cycles(10);
        wr(5'h08, 16'h0800);
        rd(5'h00, v1);
        check("R2 counted down", 16'(v1 < 16'h0005), 16'h0001);
        cycles(20);
        rd(5'h00, v2);
        check("R3 held while halted", v2, v1);

        // R7 / R8 first expiry with interrupt
        cur_req = "R8";
        wr(5'h0C, 16'h2000);
        wr(5'h00, 16'h0000);
        irq_cnt = 0; rst_cnt = 0;
        wr(5'h08, 16'h0000);
        cycles(30);
        wr(5'h08, 16'h0800);
        check("R8 one irq pulse", 16'(irq_cnt), 16'h0001);
        check("R7 no reset on first", 16'(rst_cnt), 16'h0000);
        rd(5'h04, v); check("R7 stage1 flag", v, 16'h0008);

        // R11 write-one-to-clear
        cur_req = "R11";
        wr(5'h04, 16'h0000);
        rd(5'h04, v); check("R11 zero write no effect", v, 16'h0008);
        wr(5'h04, 16'h0008);
        rd(5'h04, v); check("R11 clear stage1", v, 16'h0000);

        // R9 second expiry, parking
        cur_req = "R9";
        wr(5'h0C, 16'h0000);
        wr(5'h00, 16'h0000);
        irq_cnt = 0; rst_cnt = 0;
        wr(5'h08, 16'h0000);
        cycles(60);
        check("R9 one reset pulse", 16'(rst_cnt), 16'h0001);
        check("R8 irq disabled", 16'(irq_cnt), 16'h0000);
        rd(5'h06, v); check("R9 stage2 flag", v, 16'h0006);
        rd(5'h00, v1); check("R9 parked at zero", v1, 16'h0000);
        cycles(20);
        rd(5'h00, v2); check("R9 still parked", v2, 16'h0000);

        // R10 no-reboot inhibit
        cur_req = "R10";
        wr(5'h04, 16'h0008);
        wr(5'h06, 16'h0002);
        rd(5'h06, v); check("R11 stage2 cleared boot kept", v, 16'h0004);
        wr(5'h08, 16'h0001);
        wr(5'h00, 16'h0000);
        rst_cnt = 0;
        cycles(60);
        check("R10 reset suppressed", 16'(rst_cnt), 16'h0000);
        rd(5'h06, v); check("R10 stage2 still recorded", v, 16'h0006);

        // R12 boot flag clear
        cur_req = "R12";
        wr(5'h06, 16'h0004);
        rd(5'h06, v); check("R12 boot cleared", v, 16'h0002);

        cycles(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule